// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block holds the 13-bit program counter of a small controller whose program memory is separate from data memory and holds 14-bit instruction words. On every instruction cycle it picks the next fetch address from one of several sources: a forced start address after reset, the fixed interrupt entry address, the next sequential word, a return address taken from an external stack, a branch target for a call or goto, or a computed jump made when software writes the low byte of the counter through the data bus.

The upper counter bits never come from an instruction directly. Software first writes them into a separate five-bit high-address staging register. A write to the low counter byte takes all five staged bits. A call or goto takes only the top two staged bits, with the other eleven bits from the instruction literal. When a call or interrupt entry is taken, the block offers the address of the following word to the external stack. Stack pushes and pops leave the staging register unchanged.

Top module: `pcu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter becomes 0x0000 and the staging register becomes 0. This happens whatever the other inputs are, and `push_en` stays low during reset.
- R2: An edge with `cyc_en` and `irq_take` high loads 0x0004. This takes priority over return, call, goto and low-byte write. In that cycle `push_en` is high and `push_addr` is the current counter plus one.
- R3: An edge with `cyc_en` high and no load request adds one to the counter. The count wraps from 0x1FFF to 0x0000.
- R4: A low-byte write (`pcl_wr`) loads bits 7:0 from `wdata` and bits 12:8 from staging bits 4:0.
- R5: A call or goto loads bits 10:0 from `instr_lit` and bits 12:11 from staging bits 4:3.
- R6: A call that is taken drives `push_en` high, with `push_addr` equal to the current counter plus one, wrapping to 0x0000. A goto never pushes.
- R7: A return (`ret_take`) loads the counter with `ret_addr`.
- R8: The staging register changes only on `latch_wr`, and then takes `wdata[4:0]`. Calls, gotos, returns and interrupts leave it unchanged. A load in the same cycle as a staging write uses the old staged value.
- R9: Among the non-interrupt loads, return beats call/goto, and call/goto beats low-byte write. A call that loses to a return does not push.
- R10: With `cyc_en` low, the counter holds its value.
- R11: `pcl_rd` always shows counter bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle advance strobe |
| irq_take | input | 1 | Interrupt entry request |
| ret_take | input | 1 | Return request from decoder |
| ret_addr | input | 13 | Address popped from external stack |
| call_take | input | 1 | Call request from decoder |
| jump_take | input | 1 | Goto request from decoder |
| instr_lit | input | 11 | Branch literal from instruction |
| pcl_wr | input | 1 | Data-bus write of the low counter byte |
| latch_wr | input | 1 | Data-bus write of the staging register |
| wdata | input | 8 | Data-bus write value |
| pc_out | output | 13 | Current fetch address |
| pcl_rd | output | 8 | Low counter byte for data-bus reads |
| latch_out | output | 5 | Staging register contents |
| push_en | output | 1 | Push strobe to external stack |
| push_addr | output | 13 | Return address offered for the push |

## Verification
Counter loads and staging writes are registered, so their results show one edge after the cycle in which the request is driven. The bench drives each request on a falling edge and reads `pc_out`, `pcl_rd` and `latch_out` on the next falling edge. The push strobe and push address are combinational from the current counter and the requests. They are checked one time unit after the inputs change, before the edge that consumes them. Expected addresses are worked out by hand from the staging bits and literals, not copied from the design.

// File: rtl/pcu_pkg.sv
// Package: shared constants and the next-address source selector.
// Assumes: a 13-bit counter, an 8-bit data bus and an 11-bit branch literal.
package pcu_pkg;

    localparam int PC_W    = 13;
    localparam int DATA_W  = 8;
    localparam int LIT_W   = 11;
    localparam int LATCH_W = PC_W - DATA_W;

    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_RESET  = 3'd1,
        SRC_IRQ    = 3'd2,
        SRC_RET    = 3'd3,
        SRC_BRANCH = 3'd4,
        SRC_PCL    = 3'd5,
        SRC_INC    = 3'd6
    } pc_src_e;

endpackage

// File: rtl/pcu_src_arb.sv
// Module: fixed-priority selection of the next counter source.
// Order: reset, interrupt, return, call/goto, low-byte write, increment.
// Nothing but reset acts without cyc_en. A push is raised only for a
// winning interrupt or a winning call.
module pcu_src_arb
    import pcu_pkg::*;
(
    input  logic    rst_n,
    input  logic    cyc_en,
    input  logic    irq_take,
    input  logic    ret_take,
    input  logic    call_take,
    input  logic    jump_take,
    input  logic    pcl_wr,
    output pc_src_e src,
    output logic    push_en
);

    // Purpose: resolve competing requests into one source.
    always_comb begin
        if (!rst_n) begin
            src = SRC_RESET;
        end else if (!cyc_en) begin
            src = SRC_HOLD;
        end else if (irq_take) begin
            src = SRC_IRQ;
        end else if (ret_take) begin
            src = SRC_RET;
        end else if (call_take || jump_take) begin
            src = SRC_BRANCH;
        end else if (pcl_wr) begin
            src = SRC_PCL;
        end else begin
            src = SRC_INC;
        end
    end

    // Purpose: push for interrupt entry, and for a call that wins.
    always_comb begin
        push_en = (src == SRC_IRQ) || ((src == SRC_BRANCH) && call_take);
    end

endmodule

// File: rtl/pcu_target_gen.sv
// Module: forms every candidate address and muxes in the selected one.
// Assumes: the staging register is at least PC_W-DATA_W bits wide.
// A branch takes the top BR_HI_W staged bits above the literal.
module pcu_target_gen
    import pcu_pkg::*;
#(
    parameter int P_PC_W    = PC_W,
    parameter int P_DATA_W  = DATA_W,
    parameter int P_LIT_W   = LIT_W,
    parameter int P_LATCH_W = LATCH_W,
    parameter logic [P_PC_W-1:0] RST_VEC = '0,
    parameter logic [P_PC_W-1:0] IRQ_VEC = 4
)(
    input  pc_src_e               src,
    input  logic [P_PC_W-1:0]     pc_q,
    input  logic [P_LATCH_W-1:0]  latch_q,
    input  logic [P_DATA_W-1:0]   wdata,
    input  logic [P_LIT_W-1:0]    instr_lit,
    input  logic [P_PC_W-1:0]     ret_addr,
    output logic [P_PC_W-1:0]     pc_nxt,
    output logic [P_PC_W-1:0]     seq_addr
);

    localparam int PCL_HI_W = P_PC_W - P_DATA_W;
    localparam int BR_HI_W  = P_PC_W - P_LIT_W;

    logic [P_PC_W-1:0] pcl_tgt;
    logic [P_PC_W-1:0] br_tgt;

    // Purpose: next sequential address; wraps at the top of program space.
    assign seq_addr = pc_q + {{(P_PC_W-1){1'b0}}, 1'b1};

    generate
        if (BR_HI_W > 0) begin : g_br_hi
            // Purpose: branch target uses the upper staged bits over the literal.
            assign br_tgt = {latch_q[P_LATCH_W-1 -: BR_HI_W], instr_lit};
        end else begin : g_br_flat
            // Purpose: literal already covers the whole counter.
            assign br_tgt = instr_lit[P_PC_W-1:0];
        end
    endgenerate

    // Purpose: computed jump uses the low staged bits over the written byte.
    assign pcl_tgt = {latch_q[PCL_HI_W-1:0], wdata};

    // Purpose: select the next counter value.
    always_comb begin
        unique case (src)
            SRC_RESET:  pc_nxt = RST_VEC;
            SRC_IRQ:    pc_nxt = IRQ_VEC;
            SRC_RET:    pc_nxt = ret_addr;
            SRC_BRANCH: pc_nxt = br_tgt;
            SRC_PCL:    pc_nxt = pcl_tgt;
            SRC_INC:    pc_nxt = seq_addr;
            default:    pc_nxt = pc_q;
        endcase
    end

endmodule

// File: rtl/pcu_hi_latch.sv
// Module: high-address staging register.
// Written only through its own strobe. Stack traffic never touches it.
// Cleared by synchronous reset.
module pcu_hi_latch #(
    parameter int P_DATA_W  = 8,
    parameter int P_LATCH_W = 5
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  latch_wr,
    input  logic [P_DATA_W-1:0]   wdata,
    output logic [P_LATCH_W-1:0]  latch_q
);

    // Purpose: capture the low bits of the bus on a staging write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (latch_wr) begin
            latch_q <= wdata[P_LATCH_W-1:0];
        end
    end

endmodule

// File: rtl/pcu_core.sv
// Module: program counter sequencing unit (top).
// Holds the fetch address and takes the next one chosen by pcu_src_arb
// and formed by pcu_target_gen. Assumes the decoder asserts at most one
// of return/call/goto/low-byte-write; the priority still settles overlaps.
module pcu_core
    import pcu_pkg::*;
#(
    parameter logic [PC_W-1:0] RST_VEC = '0,
    parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en,
    input  logic               irq_take,
    input  logic               ret_take,
    input  logic [PC_W-1:0]    ret_addr,
    input  logic               call_take,
    input  logic               jump_take,
    input  logic [LIT_W-1:0]   instr_lit,
    input  logic               pcl_wr,
    input  logic               latch_wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [PC_W-1:0]    pc_out,
    output logic [DATA_W-1:0]  pcl_rd,
    output logic [LATCH_W-1:0] latch_out,
    output logic               push_en,
    output logic [PC_W-1:0]    push_addr
);

    pc_src_e           src;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   pc_nxt;
    logic [PC_W-1:0]   seq_addr;
    logic [LATCH_W-1:0] latch_q;

    pcu_src_arb u_arb (
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .irq_take  (irq_take),
        .ret_take  (ret_take),
        .call_take (call_take),
        .jump_take (jump_take),
        .pcl_wr    (pcl_wr),
        .src       (src),
        .push_en   (push_en)
    );

    pcu_hi_latch #(
        .P_DATA_W  (DATA_W),
        .P_LATCH_W (LATCH_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_wr (latch_wr),
        .wdata    (wdata),
        .latch_q  (latch_q)
    );

    pcu_target_gen #(
        .P_PC_W    (PC_W),
        .P_DATA_W  (DATA_W),
        .P_LIT_W   (LIT_W),
        .P_LATCH_W (LATCH_W),
        .RST_VEC   (RST_VEC),
        .IRQ_VEC   (IRQ_VEC)
    ) u_tgt (
        .src       (src),
        .pc_q      (pc_q),
        .latch_q   (latch_q),
        .wdata     (wdata),
        .instr_lit (instr_lit),
        .ret_addr  (ret_addr),
        .pc_nxt    (pc_nxt),
        .seq_addr  (seq_addr)
    );

    // Purpose: the counter register; the arbiter already folds in reset.
    always_ff @(posedge clk) begin
        pc_q <= pc_nxt;
    end

    assign pc_out    = pc_q;
    assign pcl_rd    = pc_q[DATA_W-1:0];
    assign latch_out = latch_q;
    assign push_addr = seq_addr;

endmodule

// File: rtl/pcu_core_chk.sv
// Module: temporal checks on pcu_core ports, attached by bind.
module pcu_core_chk
    import pcu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_en,
    input logic               irq_take,
    input logic               ret_take,
    input logic [PC_W-1:0]    ret_addr,
    input logic               call_take,
    input logic               jump_take,
    input logic               pcl_wr,
    input logic               latch_wr,
    input logic [PC_W-1:0]    pc_out,
    input logic [LATCH_W-1:0] latch_out,
    input logic               push_en
);

    AST_RESET_VECTOR: assert property (@(posedge clk)
        !rst_n |=> (pc_out == '0) && (latch_out == '0)); // R1

    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && irq_take |=> pc_out == 13'h0004); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && !irq_take && !ret_take && !call_take && !jump_take && !pcl_wr
        |=> pc_out == $past(pc_out) + 13'd1); // R3

    AST_PUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> cyc_en && (irq_take || (call_take && !ret_take))); // R6

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && !irq_take && ret_take |=> pc_out == $past(ret_addr)); // R7

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_wr |=> $stable(latch_out)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(pc_out)); // R10

endmodule

bind pcu_core pcu_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .irq_take  (irq_take),
    .ret_take  (ret_take),
    .ret_addr  (ret_addr),
    .call_take (call_take),
    .jump_take (jump_take),
    .pcl_wr    (pcl_wr),
    .latch_wr  (latch_wr),
    .pc_out    (pc_out),
    .latch_out (latch_out),
    .push_en   (push_en)
);

// File: tb/pcu_core_test.sv
`timescale 1ns/1ps
module pcu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0, irq_take = 1'b0, ret_take = 1'b0;
    logic        call_take = 1'b0, jump_take = 1'b0, pcl_wr = 1'b0, latch_wr = 1'b0;
    logic [12:0] ret_addr = '0;
    logic [10:0] instr_lit = '0;
    logic [7:0]  wdata = '0;
    logic [12:0] pc_out, push_addr;
    logic [7:0]  pcl_rd;
    logic [4:0]  latch_out;
    logic        push_en;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pcu_core uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .irq_take(irq_take),
        .ret_take(ret_take), .ret_addr(ret_addr), .call_take(call_take),
        .jump_take(jump_take), .instr_lit(instr_lit), .pcl_wr(pcl_wr),
        .latch_wr(latch_wr), .wdata(wdata), .pc_out(pc_out), .pcl_rd(pcl_rd),
        .latch_out(latch_out), .push_en(push_en), .push_addr(push_addr)
    );

    typedef struct packed {
        logic        en, irq, ret, call, jmp, pclw, latw;
        logic [7:0]  wd;
        logic [10:0] lit;
        logic [12:0] ra;
        logic [12:0] xpc;
        logic        xpush;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 11'h000, 13'h0000, 13'h0001, 1'b0}, // R3 step
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h1B, 11'h000, 13'h0000, 13'h0002, 1'b0}, // R8 stage write
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 11'h155, 13'h0000, 13'h1955, 1'b1}, // R5 R6 call
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h40, 11'h000, 13'h0000, 13'h1B40, 1'b0}, // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 11'h000, 13'h0000, 13'h1B40, 1'b0}, // R10
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 11'h7FF, 13'h0000, 13'h1FFF, 1'b0}, // R5 goto
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 11'h000, 13'h0000, 13'h0000, 1'b0}, // R3 wrap
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 11'h000, 13'h0ABC, 13'h0ABC, 1'b0}, // R7
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 11'h000, 13'h0000, 13'h0004, 1'b1}, // R2
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 11'h001, 13'h0000, 13'h0004, 1'b1}, // R2 over call
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 8'h00, 11'h000, 13'h1234, 13'h1234, 1'b0}, // R9
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 8'h99, 11'h002, 13'h0000, 13'h1802, 1'b1}, // R9
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h05, 11'h000, 13'h0000, 13'h1B05, 1'b0}, // R8 old stage
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h77, 11'h000, 13'h0000, 13'h0577, 1'b0}, // R4
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 11'h100, 13'h0000, 13'h0100, 1'b1}  // R5 R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cyc_en = 1'b0; irq_take = 1'b0; ret_take = 1'b0; call_take = 1'b0;
        jump_take = 1'b0; pcl_wr = 1'b0; latch_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [12:0] prev_pc;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc", pc_out, 13'h0000);
        check("R1 stage", latch_out, 5'h00);
        check("R1 push", push_en, 1'b0);
        rst_n = 1'b1;
        prev_pc = 13'h0000;

        for (int i = 0; i < NV; i++) begin
            cyc_en = VEC[i].en; irq_take = VEC[i].irq; ret_take = VEC[i].ret;
            call_take = VEC[i].call; jump_take = VEC[i].jmp; pcl_wr = VEC[i].pclw;
            latch_wr = VEC[i].latw; wdata = VEC[i].wd; instr_lit = VEC[i].lit;
            ret_addr = VEC[i].ra;
            #1;
            check("R6/R9 push_en", push_en, VEC[i].xpush);
            if (VEC[i].xpush)
                check("R6/R2 push_addr", push_addr, prev_pc + 13'd1);
            @(posedge clk);
            @(negedge clk);
            check("vector pc", pc_out, VEC[i].xpc);
            check("R11 pcl_rd", pcl_rd, {24'h0, VEC[i].xpc[7:0]});
            prev_pc = VEC[i].xpc;
        end
        idle_inputs();
        check("R8 stage after table", latch_out, 5'h05);

        // R8: only low five bits are staged; return and interrupt leave it alone
        latch_wr = 1'b1; wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        latch_wr = 1'b0;
        check("R8 stage width", latch_out, 5'h1F);
        cyc_en = 1'b1; ret_take = 1'b1; ret_addr = 13'h0333;
        @(posedge clk); @(negedge clk);
        ret_take = 1'b0; irq_take = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        check("R8 stage kept over ret/irq", latch_out, 5'h1F);

        // R4 + R6: computed jump to the top, then a call whose push wraps
        cyc_en = 1'b1; pcl_wr = 1'b1; wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        pcl_wr = 1'b0;
        check("R4 top", pc_out, 13'h1FFF);
        call_take = 1'b1; instr_lit = 11'h0AA;
        #1;
        check("R6 push wrap", push_addr, 13'h0000);
        check("R6 push on call", push_en, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R5 call target", pc_out, 13'h18AA);
        call_take = 1'b0; jump_take = 1'b1;
        #1;
        check("R6 goto no push", push_en, 1'b0);
        @(posedge clk); @(negedge clk);
        idle_inputs();

        // R1: reset wins over an interrupt request
        rst_n = 1'b0; cyc_en = 1'b1; irq_take = 1'b1;
        #1;
        check("R1 push in reset", push_en, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R1 pc over irq", pc_out, 13'h0000);
        check("R1 stage cleared", latch_out, 5'h00);
        idle_inputs();
        rst_n = 1'b1;

        // R10: held with no cycle strobe even with requests present
        ret_take = 1'b1; ret_addr = 13'h1111; call_take = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 hold", pc_out, 13'h0000);
        idle_inputs();

        finish_run();
    end

endmodule